// File: doc/BRIEF.md
# Memory Dependence Tracking Unit

This block decides when each in-flight memory operation of an out-of-order core may issue. The operations are loads, stores, atomics and fences from a few hardware threads. Each operation is inserted into a fixed table of slots with its sequence number. If the operation must wait, it is attached to one producer. The producer is one of two things:
- an outstanding fence, for an operation that a fence orders;
- otherwise, a store sequence number supplied by an external predictor on the insert port.

A waiting operation becomes memory-ready when its producer completes. It is announced on the ready output once its registers are also ready.

Commands arrive on a single command port:
- register-ready, which marks an operation's source registers as available;
- non-speculative ready, which releases a held non-speculative operation;
- complete;
- reschedule;
- replay;
- per-thread squash.

The dependents of each producer are kept as a bit vector over table slots. Completing a store, an atomic or a fence therefore releases all of its waiters in one edge. Ready operations leave on the output one per cycle, lowest slot first. Non-speculative operations skip both the predictor and the fences, and wait only for an explicit command. Fences always take this path.

Top module: `mdt_core`

## Requirements
- R1: `ins_full` is high exactly when all DEPTH slots hold an operation. A completed or squashed operation frees its slot for reuse. A new operation takes the lowest free slot.
- R2: With no fence outstanding, a speculative load, store or atomic waits on the live table entry whose sequence number equals `pred_seq`. If `pred_seq` is 0, or matches no live entry, the operation is memory-ready at once. It appears on the output in the cycle after insertion when `ins_regs_ready` is 1.
- R3: A load or atomic inserted while the load fence is outstanding waits on that fence's number. A store or atomic inserted while the store fence is outstanding waits on the store fence's number. A load is not held by a store fence.
- R4: A full fence (kind 3) records its number as both the load fence and the store fence. A write fence (kind 4) records only the store fence.
- R5: Completing an operation clears each fence flag whose recorded number equals the completed sequence number. Each fence flag is cleared separately.
- R6: Completing a store (kind 1), atomic (kind 2) or fence marks every waiter of that entry memory-ready. Waiters whose registers are ready are sent to the output. Completing a load (kind 0) wakes nobody.
- R7: The register-ready command (op 0) sends a speculative entry to the output only if the entry is already memory-ready. Otherwise the entry keeps waiting.
- R8: Each insertion that waits on a live producer adds one to a counter:
  - `conf_loads` when the inserted operation is a load;
  - `conf_stores` when it is a store or an atomic.
- R9: Squash (op 5) removes every entry of `cmd_tid` whose sequence number is greater than `cmd_seq`, including any queued replay of it. In the next cycle, the squash point and thread appear on `pred_sq_*` for one cycle.
- R10: Reschedule (op 3) puts a live entry on the replay list. Replay (op 4) sends every listed entry to the output and empties the list.
- R11: A non-speculative operation (`ins_nonspec`=1) ignores the predictor, the fences and register readiness. It appears on the output only after the non-speculative ready command (op 1). The same holds for every fence.
- R12: The output carries at most one operation per cycle. When several entries are ready, the lowest slot goes first. Insert and command never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert an operation this cycle |
| ins_kind | input | 3 | 0 load, 1 store, 2 atomic, 3 full fence, 4 write fence |
| ins_nonspec | input | 1 | Operation is non-speculative |
| ins_seq | input | SEQ_W | Sequence number (non-zero, unique) |
| ins_tid | input | TID_W | Hardware thread |
| ins_regs_ready | input | 1 | Source registers already available |
| pred_seq | input | SEQ_W | Predicted producing store, 0 for none |
| ins_full | output | 1 | All slots occupied |
| cmd_valid | input | 1 | Command valid |
| cmd_op | input | 3 | 0 regs ready, 1 non-spec ready, 2 complete, 3 reschedule, 4 replay, 5 squash |
| cmd_seq | input | SEQ_W | Target sequence number or squash point |
| cmd_tid | input | TID_W | Thread for squash |
| out_valid | output | 1 | An operation is ready to issue |
| out_seq | output | SEQ_W | Its sequence number |
| out_tid | output | TID_W | Its thread |
| pred_sq_valid | output | 1 | Squash forwarded to the predictor |
| pred_sq_seq | output | SEQ_W | Forwarded squash point |
| pred_sq_tid | output | TID_W | Forwarded squash thread |
| conf_loads | output | CNT_W | Loads that had to wait on a producer |
| conf_stores | output | CNT_W | Stores and atomics that had to wait on a producer |

## Verification
Every insert or command takes effect at the rising edge that samples it. A resulting ready operation is on `out_seq` during the next cycle. `ins_full`, the conflict counters and the `pred_sq_*` forward also change on that edge. The bench drives on falling edges and tests the counters, `ins_full` and the squash forward on the falling edge right after the sampling edge. A monitor samples the ready output shortly after each rising edge. It compares each announcement with the next entry of an in-order expectation queue, and counts any announcement that arrives with nothing expected as a failure. After each scenario the bench waits a few idle cycles and requires the queue to be empty, so both missing and early outputs are caught.

// File: rtl/mdt_pkg.sv
// Shared encodings for the memory dependence tracking unit.
package mdt_pkg;
    // Operation kinds carried on ins_kind.
    typedef enum logic [2:0] {
        K_LOAD       = 3'd0,
        K_STORE      = 3'd1,
        K_ATOMIC     = 3'd2,
        K_FENCE_FULL = 3'd3,
        K_FENCE_WR   = 3'd4
    } kind_e;

    // Commands carried on cmd_op.
    typedef enum logic [2:0] {
        C_REGS    = 3'd0,
        C_NSRDY   = 3'd1,
        C_DONE    = 3'd2,
        C_RESCHED = 3'd3,
        C_REPLAY  = 3'd4,
        C_SQUASH  = 3'd5
    } cmd_e;
endpackage

// File: rtl/mdt_lowest.sv
// Priority picker: reports whether any request bit is set and the index
// of the lowest one. Assumes IW is wide enough to index N.
module mdt_lowest #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mdt_match.sv
// Associative lookup of a sequence number among live slots. A key of zero
// never hits. Assumes live tags are unique; the lowest slot wins otherwise.
module mdt_match #(
    parameter int N  = 16,
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  live,
    input  logic [W-1:0]  tags [N],
    input  logic [W-1:0]  key,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Compare every live tag against the key.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i] && (key != '0) && (tags[i] == key)) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mdt_core.sv
// Memory dependence tracking unit.
// Holds DEPTH in-flight memory operations. Each operation waits on one
// producer: an outstanding fence, or otherwise the predicted store. Each
// producer's waiters are a bit vector over slots, so a completion releases
// all of them at one edge. Ready operations leave one per cycle, lowest
// slot first.
// Assumes: sequence numbers are non-zero, unique among live entries and
// grow without wrapping within a thread; insert and command never share a
// cycle; no insert is offered while ins_full is high.
module mdt_core
    import mdt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SEQ_W = 16,
    parameter int TID_W = 2,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [2:0]       ins_kind,
    input  logic             ins_nonspec,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [TID_W-1:0] ins_tid,
    input  logic             ins_regs_ready,
    input  logic [SEQ_W-1:0] pred_seq,
    output logic             ins_full,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [SEQ_W-1:0] cmd_seq,
    input  logic [TID_W-1:0] cmd_tid,
    output logic             out_valid,
    output logic [SEQ_W-1:0] out_seq,
    output logic [TID_W-1:0] out_tid,
    output logic             pred_sq_valid,
    output logic [SEQ_W-1:0] pred_sq_seq,
    output logic [TID_W-1:0] pred_sq_tid,
    output logic [CNT_W-1:0] conf_loads,
    output logic [CNT_W-1:0] conf_stores
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // Per-slot state.
    logic [DEPTH-1:0] valid_q, memrdy_q, regrdy_q, ns_q, pend_q, replay_q;
    logic [SEQ_W-1:0] seq_q  [DEPTH];
    logic [TID_W-1:0] tid_q  [DEPTH];
    kind_e            kind_q [DEPTH];
    logic [DEPTH-1:0] deps_q [DEPTH];

    // Fence tracking, counters and the squash forward.
    logic             ld_bar_q, st_bar_q;
    logic [SEQ_W-1:0] ld_sn_q, st_sn_q;
    logic [CNT_W-1:0] cl_q, cs_q;
    logic             psv_q;
    logic [SEQ_W-1:0] psseq_q;
    logic [TID_W-1:0] pstid_q;

    // Decoded insert.
    kind_e            in_kind;
    logic             in_fence, in_ns, in_ldside, in_stside, ins_take;
    logic [SEQ_W-1:0] prod_key;

    // Decoded command.
    cmd_e             c_op;
    logic             is_regs, is_nsrdy, is_done, is_resch, is_replay, is_sq;

    // Lookup and picker results.
    logic             free_any, prod_hit, cmd_hit;
    logic [IW-1:0]    free_idx, pick_idx, prod_idx, cmd_idx;
    logic [DEPTH-1:0] kill, wake;

    assign in_kind = kind_e'(ins_kind);
    assign c_op    = cmd_e'(cmd_op);

    // Classify the inserted operation and choose the producer it waits on.
    always_comb begin
        in_fence  = (in_kind == K_FENCE_FULL) || (in_kind == K_FENCE_WR);
        in_ns     = ins_nonspec || in_fence;
        in_ldside = (in_kind == K_LOAD) || (in_kind == K_ATOMIC);
        in_stside = (in_kind == K_STORE) || (in_kind == K_ATOMIC);
        if (in_ns)                      prod_key = '0;
        else if (in_ldside && ld_bar_q) prod_key = ld_sn_q;
        else if (in_stside && st_bar_q) prod_key = st_sn_q;
        else                            prod_key = pred_seq;
    end

    // Decode the command port.
    always_comb begin
        is_regs   = cmd_valid && (c_op == C_REGS);
        is_nsrdy  = cmd_valid && (c_op == C_NSRDY);
        is_done   = cmd_valid && (c_op == C_DONE);
        is_resch  = cmd_valid && (c_op == C_RESCHED);
        is_replay = cmd_valid && (c_op == C_REPLAY);
        is_sq     = cmd_valid && (c_op == C_SQUASH);
    end

    mdt_lowest #(.N(DEPTH), .IW(IW)) u_free (
        .req(~valid_q), .any(free_any), .idx(free_idx)
    );
    mdt_lowest #(.N(DEPTH), .IW(IW)) u_pick (
        .req(pend_q), .any(out_valid), .idx(pick_idx)
    );
    mdt_match #(.N(DEPTH), .W(SEQ_W), .IW(IW)) u_prod (
        .live(valid_q), .tags(seq_q), .key(prod_key), .hit(prod_hit), .idx(prod_idx)
    );
    mdt_match #(.N(DEPTH), .W(SEQ_W), .IW(IW)) u_cmd (
        .live(valid_q), .tags(seq_q), .key(cmd_seq), .hit(cmd_hit), .idx(cmd_idx)
    );

    assign ins_take = ins_valid && free_any;

    // Slots leaving the table: the squashed younger entries and the completed one.
    always_comb begin
        kill = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (is_sq && valid_q[i] && (tid_q[i] == cmd_tid) && (seq_q[i] > cmd_seq))
                kill[i] = 1'b1;
        end
        if (is_done && cmd_hit) kill[cmd_idx] = 1'b1;
    end

    // Waiters released by a completing store, atomic or fence.
    always_comb begin
        wake = '0;
        if (is_done && cmd_hit && (kind_q[cmd_idx] != K_LOAD)) wake = deps_q[cmd_idx];
    end

    // Table, fence, counter and forward state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            memrdy_q <= '0;
            regrdy_q <= '0;
            ns_q     <= '0;
            pend_q   <= '0;
            replay_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                seq_q[i]  <= '0;
                tid_q[i]  <= '0;
                kind_q[i] <= K_LOAD;
                deps_q[i] <= '0;
            end
            ld_bar_q <= 1'b0;
            st_bar_q <= 1'b0;
            ld_sn_q  <= '0;
            st_sn_q  <= '0;
            cl_q     <= '0;
            cs_q     <= '0;
            psv_q    <= 1'b0;
            psseq_q  <= '0;
            pstid_q  <= '0;
        end else begin
            if (out_valid) pend_q[pick_idx] <= 1'b0;

            psv_q <= is_sq;
            if (is_sq) begin
                psseq_q <= cmd_seq;
                pstid_q <= cmd_tid;
            end

            if (ins_take) begin
                valid_q[free_idx]  <= 1'b1;
                seq_q[free_idx]    <= ins_seq;
                tid_q[free_idx]    <= ins_tid;
                kind_q[free_idx]   <= in_kind;
                ns_q[free_idx]     <= in_ns;
                regrdy_q[free_idx] <= ins_regs_ready;
                replay_q[free_idx] <= 1'b0;
                deps_q[free_idx]   <= '0;
                memrdy_q[free_idx] <= !prod_hit;
                pend_q[free_idx]   <= !prod_hit && !in_ns && ins_regs_ready;
                if (prod_hit) begin
                    deps_q[prod_idx][free_idx] <= 1'b1;
                    if (in_kind == K_LOAD) cl_q <= cl_q + 1'b1;
                    else                   cs_q <= cs_q + 1'b1;
                end
                if (in_kind == K_FENCE_FULL) begin
                    ld_bar_q <= 1'b1;
                    ld_sn_q  <= ins_seq;
                    st_bar_q <= 1'b1;
                    st_sn_q  <= ins_seq;
                end else if (in_kind == K_FENCE_WR) begin
                    st_bar_q <= 1'b1;
                    st_sn_q  <= ins_seq;
                end
            end

            if (is_regs && cmd_hit) begin
                regrdy_q[cmd_idx] <= 1'b1;
                if (memrdy_q[cmd_idx] && !ns_q[cmd_idx]) pend_q[cmd_idx] <= 1'b1;
            end
            if (is_nsrdy && cmd_hit && ns_q[cmd_idx]) pend_q[cmd_idx] <= 1'b1;
            if (is_resch && cmd_hit) replay_q[cmd_idx] <= 1'b1;
            if (is_replay) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (replay_q[i]) begin
                        pend_q[i]   <= 1'b1;
                        replay_q[i] <= 1'b0;
                    end
                end
            end

            if (is_done) begin
                if (ld_bar_q && (ld_sn_q == cmd_seq)) ld_bar_q <= 1'b0;
                if (st_bar_q && (st_sn_q == cmd_seq)) st_bar_q <= 1'b0;
            end
            for (int j = 0; j < DEPTH; j++) begin
                if (wake[j]) begin
                    memrdy_q[j] <= 1'b1;
                    if (valid_q[j] && regrdy_q[j] && !ns_q[j]) pend_q[j] <= 1'b1;
                end
            end

            for (int i = 0; i < DEPTH; i++) begin
                if (kill[i]) begin
                    valid_q[i]  <= 1'b0;
                    pend_q[i]   <= 1'b0;
                    replay_q[i] <= 1'b0;
                    deps_q[i]   <= '0;
                    for (int p = 0; p < DEPTH; p++) deps_q[p][i] <= 1'b0;
                end
            end
        end
    end

    assign ins_full      = &valid_q;
    assign out_seq       = seq_q[pick_idx];
    assign out_tid       = tid_q[pick_idx];
    assign pred_sq_valid = psv_q;
    assign pred_sq_seq   = psseq_q;
    assign pred_sq_tid   = pstid_q;
    assign conf_loads    = cl_q;
    assign conf_stores   = cs_q;
endmodule

// File: rtl/mdt_chk.sv
// Port-level checker for mdt_core, attached through bind. Checks the usage
// rules and the timing of the squash forward, the output and the counters.
module mdt_chk #(
    parameter int SEQ_W = 16,
    parameter int TID_W = 2,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             ins_full,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [SEQ_W-1:0] cmd_seq,
    input logic [TID_W-1:0] cmd_tid,
    input logic             out_valid,
    input logic [SEQ_W-1:0] out_seq,
    input logic [TID_W-1:0] out_tid,
    input logic             pred_sq_valid,
    input logic [SEQ_W-1:0] pred_sq_seq,
    input logic [TID_W-1:0] pred_sq_tid,
    input logic [CNT_W-1:0] conf_loads,
    input logic [CNT_W-1:0] conf_stores
);
    // R12: insert and command never share a cycle.
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_valid && cmd_valid));

    // R1: no insert is offered against a full table.
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ins_full |-> !ins_valid);

    // R9: a squash is forwarded with its point and thread one cycle later.
    p_sq_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5) |=>
            (pred_sq_valid && pred_sq_seq == $past(cmd_seq) && pred_sq_tid == $past(cmd_tid)));

    // R9: no forward without a squash.
    p_sq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == 3'd5) |=> !pred_sq_valid);

    // R9: nothing younger of the squashed thread is announced after the squash.
    p_sq_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5) |=>
            !(out_valid && out_tid == $past(cmd_tid) && out_seq > $past(cmd_seq)));

    // R12: an announced operation always carries a real sequence number.
    p_out_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_seq != '0));

    // R8: each counter holds or steps by one.
    p_cnt_ld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (conf_loads == $past(conf_loads) || conf_loads == $past(conf_loads) + 1'b1));
    p_cnt_st_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (conf_stores == $past(conf_stores) || conf_stores == $past(conf_stores) + 1'b1));

    // R8: one insertion bumps at most one counter.
    p_cnt_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !(conf_loads != $past(conf_loads) && conf_stores != $past(conf_stores)));
endmodule

bind mdt_core mdt_chk #(.SEQ_W(SEQ_W), .TID_W(TID_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_mdt_core.sv
`timescale 1ns/1ps
// Scoreboard bench for mdt_core: drivers push expected ready operations
// into a queue; a monitor pops and compares them as the design emits them.
module sim_mdt_core;
    localparam int DEPTH = 16;
    localparam int SEQ_W = 16;
    localparam int TID_W = 2;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ins_valid = 1'b0;
    logic [2:0]       ins_kind = '0;
    logic             ins_nonspec = 1'b0;
    logic [SEQ_W-1:0] ins_seq = '0;
    logic [TID_W-1:0] ins_tid = '0;
    logic             ins_regs_ready = 1'b0;
    logic [SEQ_W-1:0] pred_seq = '0;
    logic             ins_full;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [SEQ_W-1:0] cmd_seq = '0;
    logic [TID_W-1:0] cmd_tid = '0;
    logic             out_valid;
    logic [SEQ_W-1:0] out_seq;
    logic [TID_W-1:0] out_tid;
    logic             pred_sq_valid;
    logic [SEQ_W-1:0] pred_sq_seq;
    logic [TID_W-1:0] pred_sq_tid;
    logic [CNT_W-1:0] conf_loads, conf_stores;

    mdt_core #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .TID_W(TID_W), .CNT_W(CNT_W)) u0 (.*);

    always #4 clk = ~clk;

    int    total = 0;
    int    bad   = 0;
    bit    fin   = 1'b0;
    int    exp_seq [$];
    string exp_tag [$];

    localparam int LD = 0, ST = 1, AT = 2, FF = 3, FW = 4;
    localparam int REGS = 0, NSRDY = 1, DONE = 2, RESCH = 3, REPLAY = 4, SQUASH = 5;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic expect_out(input int s, input string tag);
        exp_seq.push_back(s);
        exp_tag.push_back(tag);
    endtask

    task automatic ins(input int k, input int s, input int t, input int p, input bit regs, input bit ns);
        @(negedge clk);
        ins_valid = 1'b1; ins_kind = 3'(k); ins_seq = SEQ_W'(s); ins_tid = TID_W'(t);
        pred_seq = SEQ_W'(p); ins_regs_ready = regs; ins_nonspec = ns;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic cmd(input int op, input int s, input int t);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_seq = SEQ_W'(s); cmd_tid = TID_W'(t);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic settle(input string tag);
        repeat (4) @(negedge clk);
        chk(exp_seq.size() == 0, tag, "outstanding expected outputs", exp_seq.size(), 0);
    endtask

    // Monitor: one ready announcement per cycle after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && out_valid) begin
                if (exp_seq.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R12 unexpected output: actual=%0d expected=none", out_seq);
                end else begin
                    int    e;
                    string tg;
                    e = exp_seq.pop_front();
                    tg = exp_tag.pop_front();
                    chk(out_seq == SEQ_W'(e), tg, "ready output", int'(out_seq), e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R12", "reset out_valid", out_valid, 0);
        chk(!ins_full, "R1", "reset ins_full", ins_full, 0);
        chk(conf_loads == 0 && conf_stores == 0, "R8", "reset counters", conf_loads + conf_stores, 0);
        chk(!pred_sq_valid, "R9", "reset forward", pred_sq_valid, 0);

        // R2: predicted store dependence.
        expect_out(10, "R2");
        ins(ST, 10, 0, 0, 1, 0);
        ins(LD, 11, 0, 10, 1, 0);
        chk(conf_loads == 1, "R8", "conf_loads after wait", conf_loads, 1);
        expect_out(12, "R2");
        ins(LD, 12, 0, 5, 1, 0);
        cmd(DONE, 12, 0);
        settle("R6");
        expect_out(11, "R6");
        cmd(DONE, 10, 0);
        cmd(DONE, 11, 0);
        settle("R2");

        // R7 and R6: register readiness against memory readiness.
        ins(LD, 20, 0, 0, 0, 0);
        settle("R7");
        expect_out(20, "R7");
        cmd(REGS, 20, 0);
        ins(ST, 21, 0, 0, 0, 0);
        ins(LD, 22, 0, 21, 0, 0);
        cmd(REGS, 22, 0);
        settle("R7");
        expect_out(22, "R6");
        cmd(DONE, 21, 0);
        expect_out(23, "R2");
        ins(ST, 23, 0, 0, 1, 0);
        ins(LD, 24, 0, 23, 0, 0);
        cmd(DONE, 23, 0);
        settle("R6");
        expect_out(24, "R7");
        cmd(REGS, 24, 0);
        expect_out(26, "R2");
        ins(ST, 26, 0, 0, 1, 0);
        ins(AT, 27, 0, 26, 1, 0);
        chk(conf_stores == 1, "R8", "conf_stores after atomic wait", conf_stores, 1);
        expect_out(27, "R6");
        cmd(DONE, 26, 0);
        cmd(DONE, 20, 0); cmd(DONE, 22, 0); cmd(DONE, 24, 0); cmd(DONE, 27, 0);
        settle("R6");
        chk(conf_loads == 3, "R8", "conf_loads", conf_loads, 3);

        // R3, R4, R5: full fence.
        ins(FF, 30, 0, 0, 1, 0);
        ins(LD, 31, 0, 0, 1, 0);
        ins(ST, 32, 0, 0, 1, 0);
        settle("R3");
        chk(conf_loads == 4 && conf_stores == 2, "R8", "counters after fence waits", conf_loads * 100 + conf_stores, 402);
        expect_out(30, "R11");
        cmd(NSRDY, 30, 0);
        expect_out(31, "R12");
        expect_out(32, "R12");
        cmd(DONE, 30, 0);
        cmd(DONE, 31, 0); cmd(DONE, 32, 0);
        expect_out(33, "R5");
        ins(LD, 33, 0, 0, 1, 0);
        cmd(DONE, 33, 0);
        settle("R5");

        // R4: write fence holds stores and atomics, not loads.
        ins(FW, 40, 0, 0, 1, 0);
        expect_out(41, "R4");
        ins(LD, 41, 0, 0, 1, 0);
        ins(ST, 42, 0, 0, 1, 0);
        cmd(DONE, 41, 0);
        ins(AT, 43, 0, 0, 1, 0);
        settle("R3");
        expect_out(43, "R12");
        expect_out(42, "R12");
        cmd(DONE, 40, 0);
        cmd(DONE, 42, 0); cmd(DONE, 43, 0);
        settle("R4");

        // R5: only the flag whose number matches is cleared.
        ins(FF, 50, 0, 0, 1, 0);
        ins(FW, 51, 0, 0, 1, 0);
        cmd(DONE, 50, 0);
        expect_out(52, "R5");
        ins(LD, 52, 0, 0, 1, 0);
        ins(ST, 53, 0, 0, 1, 0);
        settle("R5");
        chk(conf_stores == 5, "R8", "conf_stores", conf_stores, 5);
        expect_out(53, "R5");
        cmd(DONE, 51, 0);
        cmd(DONE, 52, 0); cmd(DONE, 53, 0);
        settle("R5");

        // R9: thread-selective squash.
        ins(LD, 60, 1, 0, 0, 0);
        ins(LD, 61, 1, 0, 0, 0);
        ins(ST, 62, 1, 0, 0, 0);
        ins(LD, 63, 0, 0, 0, 0);
        cmd(RESCH, 61, 1);
        cmd(SQUASH, 60, 1);
        chk(pred_sq_valid && pred_sq_seq == 60 && pred_sq_tid == 1, "R9", "squash forward seq",
            int'(pred_sq_seq), 60);
        @(negedge clk);
        chk(!pred_sq_valid, "R9", "forward lasts one cycle", pred_sq_valid, 0);
        cmd(REPLAY, 0, 0);
        cmd(REGS, 61, 1);
        settle("R9");
        expect_out(63, "R9");
        cmd(REGS, 63, 0);
        expect_out(60, "R9");
        cmd(REGS, 60, 1);
        settle("R9");

        // R10: reschedule and replay.
        cmd(RESCH, 60, 1);
        cmd(RESCH, 63, 0);
        settle("R10");
        expect_out(60, "R10");
        expect_out(63, "R10");
        cmd(REPLAY, 0, 0);
        settle("R10");
        cmd(REPLAY, 0, 0);
        settle("R10");
        cmd(DONE, 60, 1); cmd(DONE, 63, 0);

        // R11: non-speculative operation.
        ins(FF, 70, 0, 0, 1, 0);
        ins(LD, 71, 0, 70, 1, 1);
        cmd(REGS, 71, 0);
        settle("R11");
        chk(conf_loads == 4, "R11", "no conflict for non-speculative", conf_loads, 4);
        expect_out(71, "R11");
        cmd(NSRDY, 71, 0);
        cmd(DONE, 70, 0); cmd(DONE, 71, 0);
        settle("R11");

        // R1 and R12: fill the table, then order of a burst.
        for (int i = 0; i < DEPTH; i++) begin
            ins(LD, 80 + i, 0, 0, 0, 0);
            if (i == DEPTH - 2) chk(!ins_full, "R1", "one slot left", ins_full, 0);
        end
        chk(ins_full, "R1", "table full", ins_full, 1);
        cmd(RESCH, 80 + DEPTH - 1, 0);
        cmd(RESCH, 80, 0);
        expect_out(80, "R12");
        expect_out(80 + DEPTH - 1, "R12");
        cmd(REPLAY, 0, 0);
        settle("R12");
        cmd(DONE, 85, 0);
        chk(!ins_full, "R1", "slot freed", ins_full, 0);
        for (int i = 0; i < DEPTH; i++) begin
            if (i != 5) cmd(DONE, 80 + i, 0);
        end
        settle("R1");
        chk(!ins_full, "R1", "empty again", ins_full, 0);

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule